// File: doc/BRIEF.md
# Task File Byte-Lane Access Decoder

This block sits between a 16-bit host bus and the data side of an ATA-style task file in a removable storage card. Each host strobe arrives with two active-low chip enables, the low address bit and a four-bit register offset. The block turns that combination into one of three things: a full-word transfer, a single byte on the low lane, or a single byte on the high lane. The target is either the 16-bit data register or the error/feature register that shares its address.

Data register traffic streams through a 512-byte sector buffer behind an internal word pointer. Word transfers and odd-byte transfers move the pointer forward by two bytes. Even-byte transfers leave it where it is, so a byte-wide host can fetch a low/high pair from the same word. On reads the shared address returns an error byte built from the card's error sources. On writes it loads a feature byte that the command logic consumes. Read data is registered and presented for one clock, with a per-lane output enable.

Top module: `tfl_lane_dec`

## Requirements
- R1: With both enables low at offset 0, 1, 8 or 9, a read returns the buffer word at the pointer on bits 15:0 with lane enables 2'b11, a write stores bits 15:0 there, and the pointer then advances by one word.
- R2: With CE2 high and CE1 low, offset 0 or 8 with A0 low accesses the even (low) byte of the current word on bits 7:0 without moving the pointer. Offset 0 or 8 with A0 high, or offset 9, accesses the odd (high) byte of the word on bits 7:0 and advances the pointer. Lane enables read 2'b01.
- R3: With CE2 low and CE1 high, offset 8 or 9 accesses the odd byte of the current word on bits 15:8 with lane enables 2'b10 and advances the pointer.
- R4: The error/feature byte is reached on bits 7:0 at offset 1 or 13 with CE2 high and CE1 low. It is reached on bits 15:8 at offset 0, 1 or 13 with CE2 low and CE1 high, and at offset 13 with both enables low.
- R5: A read of the error byte returns the error source input with bit 5 forced to 0 while the error-active input is high, and 8'h00 while it is low.
- R6: A write to the error/feature address loads the addressed byte lane into the feature output register, and leaves the buffer and the pointer untouched.
- R7: With both enables high, or at any offset other than 0, 1, 8, 9 and 13, a strobe has no effect: no lane enable, zero read data, no buffer, pointer or feature change.
- R8: Read data and lane enables appear in the clock after the read strobe is sampled and last one clock; a lane whose enable is low reads as zero.
- R9: The pointer wraps from the last word of the 512-byte buffer to word 0.
- R10: A strobe cycle with both read and write high performs the write only, and produces no read data.
- R11: After reset the feature register, the pointer, the read data and the lane enables are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for strobes and state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_ce1_n | input | 1 | Active-low enable for the low byte lane |
| host_ce2_n | input | 1 | Active-low enable for the high byte lane |
| host_a0 | input | 1 | Low address bit choosing even or odd byte |
| host_offs | input | 4 | Task file register offset |
| host_rd | input | 1 | Read strobe, one clock per access |
| host_wr | input | 1 | Write strobe, one clock per access |
| host_wdata | input | 16 | Host write data |
| err_active | input | 1 | Status error bit; error byte is valid only while high |
| err_src | input | 8 | Error sources: bit 7 bad block, bit 6 uncorrectable |
| host_rdata | output | 16 | Registered read data, unselected lanes zero |
| host_rdata_oe | output | 2 | Per-lane read enable, bit 1 high lane, bit 0 low lane |
| feature_q | output | 8 | Feature byte last written by the host |

## Verification
The pointer is hidden, and the buffer has no reset, so the bench first fills all 256 words with a known pattern. A model pointer and model contents then track each access. The hardest condition is proving that an even-byte access, an error/feature write or a rejected strobe left the pointer alone, and that a byte write reached the right half-word. The bench checks this at the ports in two ways. The next word read must return the model's word. Then the bench reads its way once around the whole buffer, past the wrap, back to words it patched with byte and mixed-strobe writes.

// File: rtl/tfl_pkg.sv
package tfl_pkg;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_WORD    = 3'd1,
    ACC_EVEN_LO = 3'd2,
    ACC_ODD_LO  = 3'd3,
    ACC_ODD_HI  = 3'd4,
    ACC_EF_LO   = 3'd5,
    ACC_EF_HI   = 3'd6
  } acc_kind_e;

  function automatic logic acc_moves_ptr(acc_kind_e k);
    return (k == ACC_WORD) || (k == ACC_ODD_LO) || (k == ACC_ODD_HI);
  endfunction

  function automatic logic acc_is_ef(acc_kind_e k);
    return (k == ACC_EF_LO) || (k == ACC_EF_HI);
  endfunction

endpackage

// File: rtl/tfl_access_decode.sv
module tfl_access_decode
  import tfl_pkg::*;
#(
  parameter int OFFS_W       = 4,
  parameter int OFF_DATA     = 0,
  parameter int OFF_ERRF     = 1,
  parameter int OFF_DUP_EVEN = 8,
  parameter int OFF_DUP_ODD  = 9,
  parameter int OFF_DUP_ERRF = 13
) (
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              a0,
  input  logic [OFFS_W-1:0] offs,
  output acc_kind_e         kind
);

  logic at_data, at_errf, at_dup_even, at_dup_odd, at_dup_errf;

  always_comb begin
    at_data     = (offs == OFFS_W'(OFF_DATA));
    at_errf     = (offs == OFFS_W'(OFF_ERRF));
    at_dup_even = (offs == OFFS_W'(OFF_DUP_EVEN));
    at_dup_odd  = (offs == OFFS_W'(OFF_DUP_ODD));
    at_dup_errf = (offs == OFFS_W'(OFF_DUP_ERRF));
  end

  always_comb begin
    kind = ACC_NONE;
    unique case ({ce2_n, ce1_n})
      2'b00: begin
        if (at_data || at_errf || at_dup_even || at_dup_odd) kind = ACC_WORD;
        else if (at_dup_errf)                                kind = ACC_EF_HI;
      end
      2'b10: begin
        if ((at_data || at_dup_even) && !a0)                 kind = ACC_EVEN_LO;
        else if (at_data || at_dup_even || at_dup_odd)       kind = ACC_ODD_LO;
        else if (at_errf || at_dup_errf)                     kind = ACC_EF_LO;
      end
      2'b01: begin
        if (at_dup_even || at_dup_odd)                       kind = ACC_ODD_HI;
        else if (at_data || at_errf || at_dup_errf)          kind = ACC_EF_HI;
      end
      default: kind = ACC_NONE;
    endcase
  end

endmodule

// File: rtl/tfl_sector_buf.sv
module tfl_sector_buf
  import tfl_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int LANE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  acc_kind_e            kind,
  input  logic                 rd_fire,
  input  logic                 wr_fire,
  input  logic [2*LANE_W-1:0]  wdata,
  output logic [2*LANE_W-1:0]  rd_word
);

  localparam int LANES = 2;
  localparam int WORDS = BUF_BYTES / LANES;
  localparam int PTR_W = $clog2(WORDS);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              ptr_en;
  logic [LANES-1:0]  lane_we;
  logic [LANE_W-1:0] lane_wd [LANES];

  // pointer: next state and register kept apart
  always_comb begin
    ptr_en = (rd_fire || wr_fire) && acc_moves_ptr(kind);
    if (ptr_q == PTR_W'(WORDS - 1)) ptr_d = '0;
    else                            ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // per-lane write enables and steering of the host byte
  always_comb begin
    lane_we    = '0;
    lane_wd[0] = wdata[LANE_W-1:0];
    lane_wd[1] = (kind == ACC_ODD_LO) ? wdata[LANE_W-1:0] : wdata[2*LANE_W-1:LANE_W];
    if (wr_fire) begin
      case (kind)
        ACC_WORD:               lane_we = 2'b11;
        ACC_EVEN_LO:            lane_we = 2'b01;
        ACC_ODD_LO, ACC_ODD_HI: lane_we = 2'b10;
        default:                lane_we = 2'b00;
      endcase
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [WORDS];

    always_ff @(posedge clk) begin
      if (lane_we[ln]) lane_mem[ptr_q] <= lane_wd[ln];
    end

    assign rd_word[ln*LANE_W +: LANE_W] = lane_mem[ptr_q];
  end

endmodule

// File: rtl/tfl_read_lanes.sv
module tfl_read_lanes
  import tfl_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_fire,
  input  acc_kind_e           kind,
  input  logic [2*LANE_W-1:0] buf_word,
  input  logic [LANE_W-1:0]   err_byte,
  output logic [2*LANE_W-1:0] rdata,
  output logic [1:0]          rdata_oe
);

  localparam logic [LANE_W-1:0] ZB = '0;

  logic [2*LANE_W-1:0] rdata_d;
  logic [1:0]          oe_d;
  logic [LANE_W-1:0]   buf_lo, buf_hi;

  always_comb begin
    buf_lo  = buf_word[LANE_W-1:0];
    buf_hi  = buf_word[2*LANE_W-1:LANE_W];
    rdata_d = '0;
    oe_d    = 2'b00;
    if (rd_fire) begin
      case (kind)
        ACC_WORD:    begin rdata_d = buf_word;           oe_d = 2'b11; end
        ACC_EVEN_LO: begin rdata_d = {ZB, buf_lo};       oe_d = 2'b01; end
        ACC_ODD_LO:  begin rdata_d = {ZB, buf_hi};       oe_d = 2'b01; end
        ACC_ODD_HI:  begin rdata_d = {buf_hi, ZB};       oe_d = 2'b10; end
        ACC_EF_LO:   begin rdata_d = {ZB, err_byte};     oe_d = 2'b01; end
        ACC_EF_HI:   begin rdata_d = {err_byte, ZB};     oe_d = 2'b10; end
        default:     begin rdata_d = '0;                 oe_d = 2'b00; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 2'b00;
    end else begin
      rdata    <= rdata_d;
      rdata_oe <= oe_d;
    end
  end

endmodule

// File: rtl/tfl_lane_dec.sv
module tfl_lane_dec
  import tfl_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int LANE_W    = 8,
  parameter int OFFS_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_ce1_n,
  input  logic                host_ce2_n,
  input  logic                host_a0,
  input  logic [OFFS_W-1:0]   host_offs,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [2*LANE_W-1:0] host_wdata,
  input  logic                err_active,
  input  logic [LANE_W-1:0]   err_src,
  output logic [2*LANE_W-1:0] host_rdata,
  output logic [1:0]          host_rdata_oe,
  output logic [LANE_W-1:0]   feature_q
);

  localparam int                ZERO_BIT  = 5;
  localparam logic [LANE_W-1:0] ERR_MASK  = ~(LANE_W'(1) << ZERO_BIT);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  acc_kind_e         kind;
  logic              rd_fire, wr_fire;
  logic [2*LANE_W-1:0] buf_word;
  logic [LANE_W-1:0] err_byte;
  logic [LANE_W-1:0] feat_d;
  logic              feat_en;

  tfl_access_decode #(.OFFS_W(OFFS_W)) u_dec (
    .ce1_n (host_ce1_n),
    .ce2_n (host_ce2_n),
    .a0    (host_a0),
    .offs  (host_offs),
    .kind  (kind)
  );

  always_comb begin
    wr_fire  = host_wr;
    rd_fire  = host_rd && !host_wr;
    err_byte = err_active ? (err_src & ERR_MASK) : '0;
    feat_en  = wr_fire && acc_is_ef(kind);
    feat_d   = (kind == ACC_EF_LO) ? host_wdata[LANE_W-1:0]
                                   : host_wdata[2*LANE_W-1:LANE_W];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  feature_q <= '0;
    else if (feat_en) feature_q <= feat_d;
  end

  tfl_sector_buf #(.BUF_BYTES(BUF_BYTES), .LANE_W(LANE_W)) u_buf (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .kind    (kind),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .wdata   (host_wdata),
    .rd_word (buf_word)
  );

  tfl_read_lanes #(.LANE_W(LANE_W)) u_rd (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_fire  (rd_fire),
    .kind     (kind),
    .buf_word (buf_word),
    .err_byte (err_byte),
    .rdata    (host_rdata),
    .rdata_oe (host_rdata_oe)
  );

endmodule

// File: rtl/tfl_lane_dec_checker.sv
module tfl_lane_dec_checker #(
  parameter int LANE_W = 8,
  parameter int OFFS_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce1_n,
  input logic                ce2_n,
  input logic [OFFS_W-1:0]   offs,
  input logic                rd,
  input logic                wr,
  input logic [2*LANE_W-1:0] rdata,
  input logic [1:0]          rdata_oe,
  input logic [LANE_W-1:0]   feat
);

  assert_word_at_errf_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !ce1_n && !ce2_n && offs == OFFS_W'(1)) |=> (rdata_oe == 2'b11));

  assert_err_bit5_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !ce2_n && ce1_n && offs == OFFS_W'(13)) |=> (rdata[LANE_W+5] == 1'b0));

  assert_feat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(feat));

  assert_no_enable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ce1_n && ce2_n) |=> (rdata_oe == 2'b00 && rdata == '0));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata_oe == 2'b00));

  assert_lo_lane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe[0] |-> (rdata[LANE_W-1:0] == '0));

  assert_hi_lane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe[1] |-> (rdata[2*LANE_W-1:LANE_W] == '0));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |=> (rdata_oe == 2'b00));

endmodule

bind tfl_lane_dec tfl_lane_dec_checker #(.LANE_W(LANE_W), .OFFS_W(OFFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .ce1_n    (host_ce1_n),
  .ce2_n    (host_ce2_n),
  .offs     (host_offs),
  .rd       (host_rd),
  .wr       (host_wr),
  .rdata    (host_rdata),
  .rdata_oe (host_rdata_oe),
  .feat     (feature_q)
);

// File: tb/tfl_lane_dec_test.sv
`timescale 1ns/1ps
module tfl_lane_dec_test;

  logic        clk;
  logic        rst_n;
  logic        ce1_n, ce2_n, a0;
  logic [3:0]  offs;
  logic        rd, wr;
  logic [15:0] wdata;
  logic        err_active;
  logic [7:0]  err_src;
  logic [15:0] rdata;
  logic [1:0]  rdata_oe;
  logic [7:0]  feature_q;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] bmem [256];
  int          bptr;

  tfl_lane_dec uut (
    .clk(clk), .rst_n(rst_n),
    .host_ce1_n(ce1_n), .host_ce2_n(ce2_n), .host_a0(a0), .host_offs(offs),
    .host_rd(rd), .host_wr(wr), .host_wdata(wdata),
    .err_active(err_active), .err_src(err_src),
    .host_rdata(rdata), .host_rdata_oe(rdata_oe), .feature_q(feature_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int i);
    return {8'(i) ^ 8'hC3, ~8'(i)};
  endfunction

  // one strobe; results sampled at the falling edge after the capturing edge
  task automatic access(logic c2, logic c1, logic a, logic [3:0] o,
                        logic r, logic w, logic [15:0] d);
    @(negedge clk);
    ce2_n = c2; ce1_n = c1; a0 = a; offs = o; rd = r; wr = w; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; ce2_n = 1'b1; ce1_n = 1'b1;
  endtask

  task automatic rd_chk(string tag, logic c2, logic c1, logic a, logic [3:0] o,
                        logic [15:0] ed, logic [1:0] eo);
    access(c2, c1, a, o, 1'b1, 1'b0, 16'h0);
    check({tag, " data"}, 32'(rdata), 32'(ed));
    check({tag, " oe"}, 32'(rdata_oe), 32'(eo));
  endtask

  task automatic word_rd(string tag);
    rd_chk(tag, 1'b0, 1'b0, 1'b0, 4'd0, bmem[bptr], 2'b11);
    bptr = (bptr + 1) % 256;
  endtask

  task automatic skip_to(int target);
    while (bptr != target) word_rd("R9 walk");
  endtask

  task automatic t_reset();
    check("R11 rdata", 32'(rdata), 32'h0);
    check("R11 oe", 32'(rdata_oe), 32'h0);
    check("R11 feature", 32'(feature_q), 32'h0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 256; i++) begin
      logic [3:0] o;
      case (i % 4)
        0: o = 4'd0; 1: o = 4'd1; 2: o = 4'd8; default: o = 4'd9;
      endcase
      access(1'b0, 1'b0, 1'b0, o, 1'b0, 1'b1, pat(i));
      bmem[i] = pat(i);
    end
    bptr = 0;
    rd_chk("R9 wrap to 0 / R1 offset 1 word", 1'b0, 1'b0, 1'b1, 4'd1, pat(0), 2'b11);
    rd_chk("R1 offset 9 word", 1'b0, 1'b0, 1'b0, 4'd9, pat(1), 2'b11);
    bptr = 2;
  endtask

  task automatic t_lowlane();
    rd_chk("R2 even off8", 1'b1, 1'b0, 1'b0, 4'd8, {8'h0, bmem[2][7:0]}, 2'b01);
    rd_chk("R2 even no advance", 1'b1, 1'b0, 1'b0, 4'd0, {8'h0, bmem[2][7:0]}, 2'b01);
    rd_chk("R2 odd off0 a0", 1'b1, 1'b0, 1'b1, 4'd0, {8'h0, bmem[2][15:8]}, 2'b01);
    rd_chk("R2 odd off9", 1'b1, 1'b0, 1'b0, 4'd9, {8'h0, bmem[3][15:8]}, 2'b01);
    bptr = 4;
  endtask

  task automatic t_highlane();
    rd_chk("R3 odd high off8", 1'b0, 1'b1, 1'b0, 4'd8, {bmem[4][15:8], 8'h0}, 2'b10);
    bptr = 5;
    access(1'b1, 1'b0, 1'b0, 4'd8, 1'b0, 1'b1, 16'hAB11);
    access(1'b0, 1'b1, 1'b1, 4'd9, 1'b0, 1'b1, 16'h2299);
    bmem[5] = 16'h2211;
    access(1'b1, 1'b0, 1'b1, 4'd9, 1'b0, 1'b1, 16'hEE33);
    bmem[6] = {8'h33, bmem[6][7:0]};
    bptr = 7;
    skip_to(5);
    word_rd("R2 R3 byte writes merged");
    word_rd("R2 odd low-lane write to high half");
  endtask

  task automatic t_errfeat();
    err_active = 1'b1; err_src = 8'hFF;
    rd_chk("R4 R5 err low lane off1", 1'b1, 1'b0, 1'b1, 4'd1, 16'h00DF, 2'b01);
    rd_chk("R4 R5 err high lane offD", 1'b0, 1'b1, 1'b0, 4'd13, 16'hDF00, 2'b10);
    rd_chk("R4 err word offD", 1'b0, 1'b0, 1'b0, 4'd13, 16'hDF00, 2'b10);
    err_src = 8'h6A;
    rd_chk("R4 R5 err high lane off0", 1'b0, 1'b1, 1'b0, 4'd0, 16'h4A00, 2'b10);
    rd_chk("R4 err low lane offD", 1'b1, 1'b0, 1'b0, 4'd13, 16'h004A, 2'b01);
    err_active = 1'b0;
    rd_chk("R5 err inactive", 1'b1, 1'b0, 1'b1, 4'd1, 16'h0000, 2'b01);
    access(1'b1, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1, 16'h773C);
    check("R6 feature low lane", 32'(feature_q), 32'h3C);
    access(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 16'hC355);
    check("R6 feature high lane off0", 32'(feature_q), 32'hC3);
    access(1'b0, 1'b0, 1'b0, 4'd13, 1'b0, 1'b1, 16'h5A77);
    check("R6 feature word offD", 32'(feature_q), 32'h5A);
    word_rd("R6 buffer and pointer untouched");
  endtask

  task automatic t_idle();
    rd_chk("R7 enables high read", 1'b1, 1'b1, 1'b0, 4'd0, 16'h0, 2'b00);
    access(1'b1, 1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 16'h00FF);
    check("R7 enables high write", 32'(feature_q), 32'h5A);
    rd_chk("R7 unsupported offset read", 1'b1, 1'b0, 1'b0, 4'd4, 16'h0, 2'b00);
    access(1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 1'b1, 16'hDEAD);
    word_rd("R7 pointer and buffer unchanged");
  endtask

  task automatic t_rdwr();
    int slot;
    slot = bptr;
    access(1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 16'hBEEF);
    check("R10 no read output", 32'(rdata_oe), 32'h0);
    bmem[slot] = 16'hBEEF;
    bptr = (bptr + 1) % 256;
    skip_to(slot);
    word_rd("R10 write took effect");
  endtask

  task automatic t_timing();
    rd_chk("R8 read visible", 1'b0, 1'b0, 1'b0, 4'd8, bmem[bptr], 2'b11);
    bptr = (bptr + 1) % 256;
    @(negedge clk);
    check("R8 oe drops after one clock", 32'(rdata_oe), 32'h0);
    check("R8 data zero after one clock", 32'(rdata), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce1_n = 1'b1; ce2_n = 1'b1; a0 = 1'b0; offs = 4'd0;
    rd = 1'b0; wr = 1'b0; wdata = 16'h0; err_active = 1'b0; err_src = 8'h0;
    bptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_lowlane();
    t_highlane();
    t_errfeat();
    t_idle();
    t_rdwr();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule